// File: doc/BRIEF.md
# DMA Channel Privilege and Security Access Guard

This block is the register-access front end of an eight-channel DMA controller. It holds each channel's register bank, which has a control word, a peripheral address, a memory address and a transfer count. Each control word carries a privilege attribute and a secure attribute. The block checks every software access against the attributes of the channel it targets. A blocked access changes nothing and reads back as zero. The block reports every illegal access on a single one-cycle pulse, which the interrupt fabric consumes.

The privilege attribute of each channel is driven continuously on a vector, so that neighbouring request-routing logic always knows which channels are privileged. Only a privileged access can change a privilege attribute. Only a secure access can change a secure attribute. A single write to the control word can set the attributes, the configuration and the enable together.

Top module: `dma_priv_guard`

## Requirements
- R1: `chan_priv_o[x]` equals the privilege attribute of channel x. A write that changes the attribute is visible on the vector one cycle after the access.
- R2: A privilege attribute changes only on a privileged write. An unprivileged write to a control word with bit 17 set leaves the attribute unchanged, still writes the remaining fields, and raises the illegal pulse.
- R3: A secure attribute changes only on a secure write. A non-secure write to a control word with bit 16 set leaves the attribute unchanged, still writes the remaining fields, and raises the illegal pulse.
- R4: An unprivileged access to any register of a privileged channel is blocked, and a blocked write leaves every register of that channel unchanged.
- R5: A non-secure access to any register of a secure channel is blocked in the same way as in R4.
- R6: `illegal_o` is high for exactly the cycle after each illegal access. It is the OR of the privilege violation and the security violation. It is low after a legal access or an idle cycle.
- R7: `rdata_o` carries the read value one cycle after the read access. A blocked read returns zero, and so does any cycle that is not a legal read.
- R8: One privileged, secure write to the control word sets enable (bit 0), configuration (bits 14:1), secure (bit 16) and privilege (bit 17) in the same cycle.
- R9: After reset, all registers and attributes are zero, which means disabled, unprivileged and non-secure.
- R10: Channel x starts at byte address 16*x. Its registers sit at offsets 0 (control), 4 (peripheral address), 8 (memory address) and 12 (count). Control bits 15 and 31:18 read as zero. An address beyond the last channel, or one that is not word-aligned, has no effect, reads zero and raises no pulse.
- R11: The count register keeps only its low CNT_W bits (16 by default). The upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| acc_priv_i | input | 1 | Access is privileged |
| acc_sec_i | input | 1 | Access is secure |
| rdata_o | output | 32 | Read data, registered |
| chan_priv_o | output | N_CH | Per-channel privilege attribute |
| illegal_o | output | 1 | Illegal-access pulse |

## Verification
All three results are due one clock edge after the access cycle: the registered read data, the illegal pulse and the updated privilege vector. Each bench task drives an access on a falling edge and removes it on the next falling edge. It samples the outputs at that second falling edge, which falls between the register update and the following edge. To confirm that the illegal pulse lasts a single cycle, a task waits one further idle cycle and samples again. Every blocked write is followed by a legal read, so that any change it should not have made is visible at the ports.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CFG_W     = 14;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned SEC_BIT   = 16;
  localparam int unsigned PRIV_BIT  = 17;
  localparam int unsigned CH_STRIDE = 4; // log2 of bytes per channel block

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PADDR = 2'd1,
    REG_MADDR = 2'd2,
    REG_COUNT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_guard_decode.sv
module dma_guard_decode
  import dma_guard_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output reg_sel_e          sel_o,
  output logic              hit_o
);
  localparam int unsigned TOP_LSB = CH_W + CH_STRIDE;

  logic upper_zero;

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_zero = (addr_i[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign ch_o  = addr_i[TOP_LSB-1:CH_STRIDE];
  assign sel_o = reg_sel_e'(addr_i[3:2]);
  assign hit_o = upper_zero && (addr_i[1:0] == 2'b00) && (int'(ch_o) < int'(N_CH));
endmodule

// File: rtl/dma_guard_check.sv
module dma_guard_check
  import dma_guard_pkg::*;
(
  input  logic     req_i,
  input  logic     we_i,
  input  logic     hit_i,
  input  reg_sel_e sel_i,
  input  logic     acc_priv_i,
  input  logic     acc_sec_i,
  input  logic     ch_priv_i,
  input  logic     ch_sec_i,
  input  logic     wr_priv_fld_i,
  input  logic     wr_sec_fld_i,
  output logic     blocked_o,
  output logic     legal_o,
  output logic     priv_ill_o,
  output logic     sec_ill_o
);
  logic acc, ctrl_wr, priv_blk, sec_blk;

  assign acc      = req_i && hit_i;
  assign ctrl_wr  = acc && we_i && (sel_i == REG_CTRL);
  assign priv_blk = acc && ch_priv_i && !acc_priv_i;
  assign sec_blk  = acc && ch_sec_i && !acc_sec_i;

  assign blocked_o  = priv_blk || sec_blk;
  assign legal_o    = acc && !blocked_o;
  // field-level violations on an otherwise legal control write
  assign priv_ill_o = priv_blk || (ctrl_wr && !acc_priv_i && wr_priv_fld_i);
  assign sec_ill_o  = sec_blk  || (ctrl_wr && !acc_sec_i && wr_sec_fld_i);
endmodule

// File: rtl/dma_guard_chan.sv
module dma_guard_chan
  import dma_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              blk_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              acc_priv_i,
  input  logic              acc_sec_i,
  output logic [DATA_W-1:0] rd_o,
  output logic              priv_o,
  output logic              sec_o
);
  logic [CFG_W:0]      cfg_q;  // bit 0 enable, CFG_W config bits above
  logic                priv_q, sec_q;
  logic [DATA_W-1:0]   paddr_q, maddr_q;
  logic [CNT_W-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      priv_q  <= 1'b0;
      sec_q   <= 1'b0;
      paddr_q <= '0;
      maddr_q <= '0;
      cnt_q   <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        REG_CTRL: begin
          cfg_q <= wdata_i[CFG_W:0];
          if (acc_priv_i) priv_q <= wdata_i[PRIV_BIT];
          if (acc_sec_i)  sec_q  <= wdata_i[SEC_BIT];
        end
        REG_PADDR: paddr_q <= wdata_i;
        REG_MADDR: maddr_q <= wdata_i;
        REG_COUNT: cnt_q   <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_o = '0;
    unique case (sel_i)
      REG_CTRL: begin
        rd_o[CFG_W:0]  = cfg_q;
        rd_o[SEC_BIT]  = sec_q;
        rd_o[PRIV_BIT] = priv_q;
      end
      REG_PADDR: rd_o = paddr_q;
      REG_MADDR: rd_o = maddr_q;
      REG_COUNT: rd_o[CNT_W-1:0] = cnt_q;
      default: ;
    endcase
  end

  assign priv_o = priv_q;
  assign sec_o  = sec_q;

  AST_PRIV_NEEDS_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_q != $past(priv_q)) |-> $past(wr_i && acc_priv_i)); // R2
  AST_SEC_NEEDS_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q != $past(sec_q)) |-> $past(wr_i && acc_sec_i)); // R3
  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |=> ($stable(paddr_q) && $stable(maddr_q) && $stable(cnt_q) && $stable(cfg_q))); // R4
endmodule

// File: rtl/dma_priv_guard.sv
module dma_priv_guard
  import dma_guard_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              acc_priv_i,
  input  logic              acc_sec_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   chan_priv_o,
  output logic              illegal_o
);
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [CH_W-1:0]   ch_idx;
  reg_sel_e          sel;
  logic              hit, blocked, legal, priv_ill, sec_ill;
  logic [N_CH-1:0]   ch_priv, ch_sec;
  logic [DATA_W-1:0] ch_rd [N_CH];
  logic              sel_priv, sel_sec;
  logic [DATA_W-1:0] sel_rd;
  logic              ill_q;
  logic [DATA_W-1:0] rdata_q;

  dma_guard_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .ch_o   (ch_idx),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  always_comb begin
    sel_priv = 1'b0;
    sel_sec  = 1'b0;
    sel_rd   = '0;
    if (hit) begin
      sel_priv = ch_priv[ch_idx];
      sel_sec  = ch_sec[ch_idx];
      sel_rd   = ch_rd[ch_idx];
    end
  end

  dma_guard_check u_check (
    .req_i         (req_i),
    .we_i          (we_i),
    .hit_i         (hit),
    .sel_i         (sel),
    .acc_priv_i    (acc_priv_i),
    .acc_sec_i     (acc_sec_i),
    .ch_priv_i     (sel_priv),
    .ch_sec_i      (sel_sec),
    .wr_priv_fld_i (wdata_i[PRIV_BIT]),
    .wr_sec_fld_i  (wdata_i[SEC_BIT]),
    .blocked_o     (blocked),
    .legal_o       (legal),
    .priv_ill_o    (priv_ill),
    .sec_ill_o     (sec_ill)
  );

  for (genvar x = 0; x < N_CH; x++) begin : g_chan
    logic this_ch;
    assign this_ch = hit && (int'(ch_idx) == x);

    dma_guard_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (legal && we_i && this_ch),
      .blk_i      (blocked && this_ch),
      .sel_i      (sel),
      .wdata_i    (wdata_i),
      .acc_priv_i (acc_priv_i),
      .acc_sec_i  (acc_sec_i),
      .rd_o       (ch_rd[x]),
      .priv_o     (ch_priv[x]),
      .sec_o      (ch_sec[x])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ill_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ill_q   <= priv_ill || sec_ill;
      rdata_q <= (legal && !we_i) ? sel_rd : '0;
    end
  end

  assign illegal_o   = ill_q;
  assign rdata_o     = rdata_q;
  assign chan_priv_o = ch_priv;

  AST_ILL_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(req_i)); // R6
  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(blocked && !we_i) |-> (rdata_o == '0)); // R7
  AST_BLOCK_RAISES_ILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(blocked) |-> illegal_o); // R6
  AST_NO_READ_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!req_i || we_i) |-> (rdata_o == '0)); // R7
endmodule

// File: tb/dma_priv_guard_bench.sv
module dma_priv_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, ap = 1'b0, as = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  cpriv;
  logic        ill;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_priv_guard u_dma_priv_guard (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .acc_priv_i(ap), .acc_sec_i(as), .rdata_o(rdata),
    .chan_priv_o(cpriv), .illegal_o(ill)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req_tag, act, exp);
    end
  endtask

  // one access; results sampled at the next falling edge
  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic p, input logic s);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; ap = p; as = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cpriv == 8'h00, "R9 priv vector", 32'(cpriv), 32'h0);
    chk(ill == 1'b0, "R9 illegal", 32'(ill), 32'h0);
    acc(1'b0, 8'h00, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0, "R9 ctrl ch0", rdata, 32'h0);
    acc(1'b0, 8'h5C, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0, "R9 count ch5", rdata, 32'h0);
  endtask

  task automatic t_single_ctrl();
    acc(1'b1, 8'h30, 32'h0003_0055, 1'b1, 1'b1);
    chk(cpriv == 8'h08, "R8 R1 priv vector", 32'(cpriv), 32'h08);
    chk(ill == 1'b0, "R8 no pulse", 32'(ill), 32'h0);
    acc(1'b0, 8'h30, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0003_0055, "R8 ctrl readback", rdata, 32'h0003_0055);
  endtask

  task automatic t_priv_block();
    acc(1'b1, 8'h34, 32'h0000_1234, 1'b0, 1'b1);
    chk(ill == 1'b1, "R4 R6 pulse", 32'(ill), 32'h1);
    idle();
    chk(ill == 1'b0, "R6 single cycle", 32'(ill), 32'h0);
    acc(1'b0, 8'h34, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0, "R4 paddr unchanged", rdata, 32'h0);
  endtask

  task automatic t_reads();
    acc(1'b1, 8'h68, 32'hCAFE_0000, 1'b0, 1'b0);
    chk(ill == 1'b0, "R6 legal write", 32'(ill), 32'h0);
    acc(1'b0, 8'h68, '0, 1'b0, 1'b0);
    chk(rdata == 32'hCAFE_0000, "R7 legal read", rdata, 32'hCAFE_0000);
    idle();
    chk(rdata == 32'h0, "R7 idle zero", rdata, 32'h0);
    acc(1'b0, 8'h30, '0, 1'b0, 1'b1);
    chk(rdata == 32'h0, "R7 blocked read", rdata, 32'h0);
    chk(ill == 1'b1, "R4 read pulse", 32'(ill), 32'h1);
  endtask

  task automatic t_priv_field();
    acc(1'b1, 8'h10, 32'h0002_000A, 1'b0, 1'b0);
    chk(ill == 1'b1, "R2 field pulse", 32'(ill), 32'h1);
    chk(cpriv[1] == 1'b0, "R2 priv kept", 32'(cpriv), 32'h08);
    acc(1'b0, 8'h10, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0000_000A, "R2 other fields", rdata, 32'h0000_000A);
  endtask

  task automatic t_secure();
    acc(1'b1, 8'h40, 32'h0001_0001, 1'b0, 1'b1);
    acc(1'b0, 8'h40, '0, 1'b0, 1'b1);
    chk(rdata == 32'h0001_0001, "R3 secure set", rdata, 32'h0001_0001);
    acc(1'b1, 8'h44, 32'h0000_00FF, 1'b1, 1'b0);
    chk(ill == 1'b1, "R5 pulse", 32'(ill), 32'h1);
    acc(1'b0, 8'h44, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0, "R5 no write", rdata, 32'h0);
    acc(1'b1, 8'h50, 32'h0001_0004, 1'b0, 1'b0);
    chk(ill == 1'b1, "R3 field pulse", 32'(ill), 32'h1);
    acc(1'b0, 8'h50, '0, 1'b0, 1'b0);
    chk(rdata == 32'h0000_0004, "R3 sec kept", rdata, 32'h0000_0004);
    acc(1'b1, 8'h38, 32'h1, 1'b0, 1'b0);
    chk(ill == 1'b1, "R6 both causes", 32'(ill), 32'h1);
  endtask

  task automatic t_map();
    acc(1'b1, 8'h80, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk(ill == 1'b0, "R10 off-map no pulse", 32'(ill), 32'h0);
    acc(1'b0, 8'h80, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0, "R10 off-map read", rdata, 32'h0);
    acc(1'b0, 8'h69, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0, "R10 unaligned read", rdata, 32'h0);
    acc(1'b1, 8'h7C, 32'hFFFF_FFFF, 1'b0, 1'b0);
    acc(1'b0, 8'h7C, '0, 1'b0, 1'b0);
    chk(rdata == 32'h0000_FFFF, "R11 count width", rdata, 32'h0000_FFFF);
    acc(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b1, 1'b1);
    chk(cpriv == 8'h09, "R1 ch0 priv", 32'(cpriv), 32'h09);
    acc(1'b0, 8'h00, '0, 1'b1, 1'b1);
    chk(rdata == 32'h0003_7FFF, "R10 ctrl layout", rdata, 32'h0003_7FFF);
  endtask

  task automatic t_priv_clear();
    acc(1'b1, 8'h30, 32'h0, 1'b1, 1'b1);
    chk(cpriv == 8'h01, "R1 priv cleared", 32'(cpriv), 32'h01);
    acc(1'b0, 8'h34, '0, 1'b0, 1'b0);
    chk(ill == 1'b0, "R4 unblocked after clear", 32'(ill), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle();
    t_reset();
    t_single_ctrl();
    t_priv_block();
    t_reads();
    t_priv_field();
    t_secure();
    t_map();
    t_priv_clear();
    idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule